// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 13-bit virtual word address into a 12-bit physical address. The upper three bits choose one of eight virtual pages and the lower ten bits give the word within the page. A page table with eight entries maps each page to one of four physical blocks of 1K words. Each entry also has a presence flag. A lookup strobe captures the translation one clock later. If the addressed page is not resident, the captured result is a page fault instead of an address.

Software or a handler loads pages through an allocation port. The block picks the physical block for the new page and shows that choice on its outputs before the load is committed. Blocks that have never been used are handed out first, in ascending order. After that, the block that was filled earliest is reused. When a reused block still holds a resident page, that page is shown as the one being evicted, and its presence flag is dropped in the same cycle that the new page takes the block. A second port marks a page as not resident without moving it in the replacement order.

Top module: `pgx_mmu`

## Requirements
- R1: For a resident page, the captured physical address is the page's 2-bit block number in bits 11:10 and the unchanged line number (virtual bits 9:0) in bits 9:0. The page number is taken from virtual bits 12:10.
- R2: For a page whose presence flag is clear, the captured result has the fault flag set and a physical address of zero.
- R3: The valid, fault and address outputs change only in the clock cycle after a lookup strobe. Valid is high for exactly that one cycle. Fault and address keep their values until the next strobe. A lookup uses the table as it stood before any update made in the same cycle.
- R4: After reset every page is absent, the valid output is low, and the next allocation targets block 0 with no eviction.
- R5: An accepted allocation makes the page resident and maps it to the block shown on the block-choice output during that cycle.
- R6: Blocks that have never been filled are chosen before any reuse, in the order 0, 1, 2, 3. The eviction flag stays low while they are being chosen.
- R7: Once all blocks have been filled, the block chosen is the one whose current tenure began earliest. If it still holds a resident page, the eviction flag is high and the eviction-page output names that page. That page becomes absent in the same cycle as the load.
- R8: An allocation request for a page that is already resident is ignored. The mapping and the block choice are left unchanged.
- R9: A drop request clears the presence flag of a resident page. Its block keeps its place in the replacement order. When that block comes up again, it is reused with the eviction flag low.
- R10: When an allocation request and a drop request arrive in the same cycle, the drop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 13 | Virtual word address to translate |
| rsp_valid | output | 1 | Pulses one cycle after a strobe |
| rsp_fault | output | 1 | Captured page-fault flag |
| rsp_paddr | output | 12 | Captured physical address |
| alloc_req | input | 1 | Request to load a page |
| alloc_page | input | 3 | Page to load |
| alloc_blk | output | 2 | Block the next load will take |
| evict_valid | output | 1 | The next load evicts a resident page |
| evict_page | output | 3 | Page that the next load evicts |
| drop_req | input | 1 | Request to mark a page absent |
| drop_page | input | 3 | Page to mark absent |

## Verification
The assertions assume the inputs settle between clock edges. They also assume that the page numbers driven on the allocation and drop ports are meaningful only while their request is high. The bench drives every input on the falling edge and returns the requests low after one cycle. The load and eviction checks rely on two facts: a page that is already resident is never accepted for loading, and an evicted page is always resident. That means the page being loaded and the page being evicted in one cycle always differ. The directed sequences include a duplicate load and a collision between a load and a drop, so those guard conditions are exercised instead of being avoided.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int PGX_PAGE_W = 3;
    localparam int PGX_BLK_W  = 2;
    localparam int PGX_LINE_W = 10;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DROP = 2'd2
    } pgx_act_e;

    function automatic pgx_act_e pgx_pick_act(input logic load_ok, input logic drop_ok);
        if (load_ok)      return ACT_LOAD;
        else if (drop_ok) return ACT_DROP;
        else              return ACT_IDLE;
    endfunction

endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
    parameter int PAGE_W = 3,
    parameter int BLK_W  = 2,
    localparam int NPAGE = 1 << PAGE_W,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [PAGE_W-1:0]       wr_page,
    input  logic [BLK_W-1:0]        wr_blk,
    input  logic                    evc_en,
    input  logic [PAGE_W-1:0]       evc_page,
    input  logic                    inv_en,
    input  logic [PAGE_W-1:0]       inv_page,
    output logic [NPAGE-1:0]        present_vec,
    output logic [NPAGE*BLK_W-1:0]  blk_flat
);

    typedef struct packed {
        logic             vld;
        logic [BLK_W-1:0] blk;
    } ent_t;

    ent_t ent_q [NPAGE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPAGE; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NPAGE; i++) begin
                if (wr_en && (wr_page == PAGE_W'(i))) begin
                    ent_q[i].vld <= 1'b1;
                    ent_q[i].blk <= wr_blk;
                end else if ((evc_en && (evc_page == PAGE_W'(i))) ||
                             (inv_en && (inv_page == PAGE_W'(i)))) begin
                    ent_q[i].vld <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < NPAGE; g++) begin : g_out
        assign present_vec[g]               = ent_q[g].vld;
        assign blk_flat[g*BLK_W +: BLK_W]   = ent_q[g].blk;
    end

    AST_FITS_MEMORY: assert property (@(posedge clk) disable iff (rst)
        $countones(present_vec) <= NBLK); // R7

endmodule

// File: rtl/pgx_repl.sv
module pgx_repl #(
    parameter int PAGE_W = 3,
    parameter int BLK_W  = 2,
    localparam int NBLK  = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [PAGE_W-1:0] take_page,
    input  logic              free_en,
    input  logic [BLK_W-1:0]  free_blk,
    output logic [BLK_W-1:0]  nxt_blk,
    output logic              nxt_evict,
    output logic [PAGE_W-1:0] nxt_page
);

    localparam logic [BLK_W:0] FULL_CNT = (BLK_W+1)'(NBLK);

    logic [BLK_W:0]     fill_q;
    logic [BLK_W-1:0]   head_q;
    logic [NBLK-1:0]    own_vld_q;
    logic [PAGE_W-1:0]  own_page_q [NBLK];
    logic               full;

    assign full      = (fill_q == FULL_CNT);
    assign nxt_blk   = full ? head_q : fill_q[BLK_W-1:0];
    assign nxt_evict = full && own_vld_q[head_q];
    assign nxt_page  = own_page_q[head_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q    <= '0;
            head_q    <= '0;
            own_vld_q <= '0;
            for (int i = 0; i < NBLK; i++) begin
                own_page_q[i] <= '0;
            end
        end else begin
            if (free_en) begin
                own_vld_q[free_blk] <= 1'b0;
            end
            if (take) begin
                if (full) begin
                    head_q <= head_q + 1'b1;
                end else begin
                    fill_q <= fill_q + 1'b1;
                end
                own_vld_q[nxt_blk]  <= 1'b1;
                own_page_q[nxt_blk] <= take_page;
            end
        end
    end

    AST_FRESH_BLOCK_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (take && !full) |-> !own_vld_q[nxt_blk]); // R6

    AST_TAKE_OWNS: assert property (@(posedge clk) disable iff (rst)
        take |=> own_vld_q[$past(nxt_blk)]); // R5

endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate #(
    parameter int PAGE_W = 3,
    parameter int BLK_W  = 2,
    parameter int LINE_W = 10,
    localparam int NPAGE = 1 << PAGE_W,
    localparam int VA_W  = PAGE_W + LINE_W,
    localparam int PA_W  = BLK_W + LINE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lk_valid,
    input  logic [VA_W-1:0]         lk_vaddr,
    input  logic [NPAGE-1:0]        present_vec,
    input  logic [NPAGE*BLK_W-1:0]  blk_flat,
    output logic                    rsp_valid,
    output logic                    rsp_fault,
    output logic [PA_W-1:0]         rsp_paddr
);

    typedef struct packed {
        logic            fault;
        logic [PA_W-1:0] pa;
    } rsp_t;

    logic [PAGE_W-1:0] page;
    logic [LINE_W-1:0] line;
    logic [BLK_W-1:0]  blk;
    rsp_t              rsp_d, rsp_q;
    logic              vld_q;

    assign page = lk_vaddr[VA_W-1:LINE_W];
    assign line = lk_vaddr[LINE_W-1:0];
    assign blk  = blk_flat[page*BLK_W +: BLK_W];

    always_comb begin
        rsp_d = '0;
        if (present_vec[page]) begin
            rsp_d.pa = {blk, line};
        end else begin
            rsp_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= '0;
        end else begin
            vld_q <= lk_valid;
            if (lk_valid) begin
                rsp_q <= rsp_d;
            end
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.pa;

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_paddr == '0)); // R2

    AST_LINE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && present_vec[page]) |=> (rsp_paddr[LINE_W-1:0] == $past(lk_vaddr[LINE_W-1:0]))); // R1

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> ($stable(rsp_paddr) && $stable(rsp_fault) && !rsp_valid)); // R3

endmodule

// File: rtl/pgx_mmu.sv
module pgx_mmu
    import pgx_pkg::*;
#(
    parameter int PAGE_W = PGX_PAGE_W,
    parameter int BLK_W  = PGX_BLK_W,
    parameter int LINE_W = PGX_LINE_W,
    localparam int NPAGE = 1 << PAGE_W,
    localparam int VA_W  = PAGE_W + LINE_W,
    localparam int PA_W  = BLK_W + LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              alloc_req,
    input  logic [PAGE_W-1:0] alloc_page,
    output logic [BLK_W-1:0]  alloc_blk,
    output logic              evict_valid,
    output logic [PAGE_W-1:0] evict_page,
    input  logic              drop_req,
    input  logic [PAGE_W-1:0] drop_page
);

    logic [NPAGE-1:0]       present_vec;
    logic [NPAGE*BLK_W-1:0] blk_flat;
    logic                   load_ok, drop_ok;
    pgx_act_e               act;
    logic                   do_load, do_drop;
    logic [BLK_W-1:0]       drop_blk;

    assign load_ok  = alloc_req && !present_vec[alloc_page];
    assign drop_ok  = drop_req && !alloc_req && present_vec[drop_page];
    assign act      = pgx_pick_act(load_ok, drop_ok);
    assign do_load  = (act == ACT_LOAD);
    assign do_drop  = (act == ACT_DROP);
    assign drop_blk = blk_flat[drop_page*BLK_W +: BLK_W];

    pgx_table #(.PAGE_W(PAGE_W), .BLK_W(BLK_W)) u_table (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (do_load),
        .wr_page     (alloc_page),
        .wr_blk      (alloc_blk),
        .evc_en      (do_load && evict_valid),
        .evc_page    (evict_page),
        .inv_en      (do_drop),
        .inv_page    (drop_page),
        .present_vec (present_vec),
        .blk_flat    (blk_flat)
    );

    pgx_repl #(.PAGE_W(PAGE_W), .BLK_W(BLK_W)) u_repl (
        .clk       (clk),
        .rst       (rst),
        .take      (do_load),
        .take_page (alloc_page),
        .free_en   (do_drop),
        .free_blk  (drop_blk),
        .nxt_blk   (alloc_blk),
        .nxt_evict (evict_valid),
        .nxt_page  (evict_page)
    );

    pgx_xlate #(.PAGE_W(PAGE_W), .BLK_W(BLK_W), .LINE_W(LINE_W)) u_xlate (
        .clk         (clk),
        .rst         (rst),
        .lk_valid    (lk_valid),
        .lk_vaddr    (lk_vaddr),
        .present_vec (present_vec),
        .blk_flat    (blk_flat),
        .rsp_valid   (rsp_valid),
        .rsp_fault   (rsp_fault),
        .rsp_paddr   (rsp_paddr)
    );

    AST_LOAD_SETS: assert property (@(posedge clk) disable iff (rst)
        load_ok |=> present_vec[$past(alloc_page)]); // R5

    AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (load_ok && evict_valid) |=> !present_vec[$past(evict_page)]); // R7

    AST_DUP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && present_vec[alloc_page]) |=> ($stable(blk_flat) && $stable(alloc_blk))); // R8

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (drop_req && !alloc_req) |=> !present_vec[$past(drop_page)]); // R9

    AST_LOAD_BEATS_DROP: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && drop_req && present_vec[drop_page] && !(load_ok && evict_valid && evict_page == drop_page))
        |=> present_vec[$past(drop_page)]); // R10

endmodule

// File: tb/sim_pgx_mmu.sv
module sim_pgx_mmu;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [12:0] lk_vaddr = '0;
    logic        rsp_valid, rsp_fault;
    logic [11:0] rsp_paddr;
    logic        alloc_req = 1'b0;
    logic [2:0]  alloc_page = '0;
    logic [1:0]  alloc_blk;
    logic        evict_valid;
    logic [2:0]  evict_page;
    logic        drop_req = 1'b0;
    logic [2:0]  drop_page = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    pgx_mmu u0 (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .alloc_req(alloc_req), .alloc_page(alloc_page),
        .alloc_blk(alloc_blk), .evict_valid(evict_valid), .evict_page(evict_page),
        .drop_req(drop_req), .drop_page(drop_page)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Strobe one lookup, check the captured result one cycle later.
    task automatic lookup(input logic [2:0] pg, input logic [9:0] ln,
                          input logic exp_fault, input logic [1:0] exp_blk, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = {pg, ln};
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " fault"}, 32'(rsp_fault), 32'(exp_fault));
        chk({req, " paddr"}, 32'(rsp_paddr), exp_fault ? 32'd0 : 32'({exp_blk, ln}));
    endtask

    // Show the choice before the load edge, then commit.
    task automatic load(input logic [2:0] pg, input logic [1:0] exp_blk,
                        input logic exp_ev, input logic [2:0] exp_evp, input string req);
        @(negedge clk);
        alloc_req  = 1'b1;
        alloc_page = pg;
        #1;
        chk({req, " block choice"}, 32'(alloc_blk), 32'(exp_blk));
        chk({req, " evict flag"}, 32'(evict_valid), 32'(exp_ev));
        if (exp_ev) chk({req, " evict page"}, 32'(evict_page), 32'(exp_evp));
        @(negedge clk);
        alloc_req = 1'b0;
    endtask

    task automatic drop(input logic [2:0] pg);
        @(negedge clk);
        drop_req  = 1'b1;
        drop_page = pg;
        @(negedge clk);
        drop_req = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R4 valid low", 32'(rsp_valid), 32'd0);
        chk("R4 first block", 32'(alloc_blk), 32'd0);
        chk("R4 no evict", 32'(evict_valid), 32'd0);
        for (int p = 0; p < 8; p++) lookup(3'(p), 10'h155, 1'b1, 2'd0, "R4 R2 absent after reset");
    endtask

    task automatic t_fill();
        load(3'd5, 2'd0, 1'b0, 3'd0, "R6 fill0");
        load(3'd1, 2'd1, 1'b0, 3'd0, "R6 fill1");
        load(3'd6, 2'd2, 1'b0, 3'd0, "R6 fill2");
        load(3'd3, 2'd3, 1'b0, 3'd0, "R6 fill3");
        lookup(3'd5, 10'h2A3, 1'b0, 2'd0, "R1 R5 page5");
        lookup(3'd3, 10'h3FF, 1'b0, 2'd3, "R1 R5 page3");
        lookup(3'd6, 10'h001, 1'b0, 2'd2, "R1 page6");
        lookup(3'd0, 10'h000, 1'b1, 2'd0, "R2 page0 absent");
    endtask

    task automatic t_hold();
        logic [11:0] prev;
        lookup(3'd1, 10'h0F0, 1'b0, 2'd1, "R3 page1");
        prev = rsp_paddr;
        @(negedge clk);
        chk("R3 valid one cycle", 32'(rsp_valid), 32'd0);
        chk("R3 paddr held", 32'(rsp_paddr), 32'(prev));
        @(negedge clk);
        chk("R3 fault held", 32'(rsp_fault), 32'd0);
    endtask

    task automatic t_dup();
        load(3'd1, 2'd0, 1'b1, 3'd5, "R8 dup request");
        lookup(3'd1, 10'h010, 1'b0, 2'd1, "R8 mapping kept");
        #1;
        chk("R8 choice kept", 32'(alloc_blk), 32'd0);
        chk("R8 evict page kept", 32'(evict_page), 32'd5);
    endtask

    task automatic t_evict();
        load(3'd7, 2'd0, 1'b1, 3'd5, "R7 evict oldest");
        lookup(3'd5, 10'h2A3, 1'b1, 2'd0, "R7 victim absent");
        lookup(3'd7, 10'h123, 1'b0, 2'd0, "R7 new page");
        load(3'd0, 2'd1, 1'b1, 3'd1, "R7 evict second");
        lookup(3'd1, 10'h010, 1'b1, 2'd0, "R7 victim2 absent");
        lookup(3'd0, 10'h3C3, 1'b0, 2'd1, "R7 page0");
    endtask

    task automatic t_drop();
        drop(3'd6);
        lookup(3'd6, 10'h001, 1'b1, 2'd0, "R9 dropped absent");
        load(3'd2, 2'd2, 1'b0, 3'd0, "R9 reuse without evict");
        lookup(3'd2, 10'h0AA, 1'b0, 2'd2, "R9 page2");
    endtask

    task automatic t_collide();
        @(negedge clk);
        alloc_req  = 1'b1;
        alloc_page = 3'd4;
        drop_req   = 1'b1;
        drop_page  = 3'd7;
        #1;
        chk("R10 choice", 32'(alloc_blk), 32'd3);
        chk("R10 evict page", 32'(evict_page), 32'd3);
        @(negedge clk);
        alloc_req = 1'b0;
        drop_req  = 1'b0;
        lookup(3'd7, 10'h055, 1'b0, 2'd0, "R10 drop ignored");
        lookup(3'd4, 10'h055, 1'b0, 2'd3, "R10 load done");
        lookup(3'd3, 10'h055, 1'b1, 2'd0, "R7 page3 evicted");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        lk_valid   = 1'b1;
        lk_vaddr   = {3'd5, 10'h077};
        alloc_req  = 1'b1;
        alloc_page = 3'd5;
        #1;
        chk("R7 wrap choice", 32'(alloc_blk), 32'd0);
        chk("R7 wrap evict page", 32'(evict_page), 32'd7);
        @(negedge clk);
        lk_valid  = 1'b0;
        alloc_req = 1'b0;
        chk("R3 old table fault", 32'(rsp_fault), 32'd1);
        lookup(3'd5, 10'h077, 1'b0, 2'd0, "R3 after load");
        lookup(3'd7, 10'h077, 1'b1, 2'd0, "R7 page7 evicted");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_hold();
        t_dup();
        t_evict();
        t_drop();
        t_collide();
        t_same_cycle();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

endmodule